// File: doc/BRIEF.md
# Four-Channel Single-Transfer DMA Arbiter

This block decides which of four DMA channels may use a bus that a CPU also uses, one transfer unit at a time. Each grant covers one byte, halfword or word. Once the bus side reports that unit as done, the bus goes back to the CPU for one cycle. The block then arbitrates again. A channel whose request line stays high therefore gets a series of separate grants, with a CPU cycle between each pair. This continues until the channel's transfer counter runs out.

Channel 0 has the highest priority and channel 3 the lowest. One exception overrides this fixed order. A request that appears during the cycle that ends a transfer, or in the cycle after it, takes the next grant ahead of any request that was already pending. The block detects an appearing request as a rising edge on the request line.

Software loads each channel's unit count with a setup strobe. Address generation and the data path sit outside this block. The grant and done pair is the only handshake. There is no data stream here, so there is no valid/ready back-pressure. The bus side stalls a grant simply by holding `xfer_done` low.

Top module: `dma_single_arb`

## Requirements
- R1: After reset, `bus_grant`, `cpu_slot` and `grant_ch` are 0, and every bit of `tc_flag` is 1. A flag value of 1 means the channel is not armed.
- R2: A `setup_stb` pulse loads `setup_cnt` into the counter of channel `setup_ch`. A non-zero count clears that channel's `tc_flag`. A zero count leaves the flag at 1.
- R3: When the arbiter is idle and an eligible request is present, `bus_grant` rises in the next cycle with `grant_ch` set to the winner. `bus_grant` stays high until `xfer_done` is sampled high, and it is low in the cycle after that.
- R4: After every grant, `cpu_slot` is high for exactly one cycle, followed by one arbitration cycle with both outputs low. Two grants are never back to back.
- R5: With no favored request, the eligible channel with the lowest index wins.
- R6: A channel whose request rises in the `xfer_done` cycle or in the `cpu_slot` cycle wins the next grant over pending requests, provided its request is still high at arbitration. If several channels qualify, the lowest index among them wins.
- R7: A rise earlier in the grant, or in the arbitration cycle itself, gets no favor. Plain fixed priority applies.
- R8: Each completed unit decrements the granted channel's counter. Going from 1 to 0 sets `tc_flag`. A channel with its flag set ignores its request line.
- R9: `unit_size` is latched from `size_sel` at each grant: 00 for byte, 01 for halfword, 10 for word. It stays constant during the grant.
- R10: A channel that holds its request receives another grant after each CPU slot, until it reaches terminal count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | NCH | Per-channel transfer request |
| setup_stb | input | 1 | Load strobe for one channel counter |
| setup_ch | input | CH_W | Channel addressed by `setup_stb` |
| setup_cnt | input | CNT_W | Unit count to load |
| size_sel | input | 2 | Unit size for the next grant |
| xfer_done | input | 1 | Bus side finished the current unit |
| bus_grant | output | 1 | Bus owned by DMA |
| grant_ch | output | CH_W | Granted channel index |
| unit_size | output | 2 | Size of the current unit |
| cpu_slot | output | 1 | One-cycle CPU ownership after a grant |
| tc_flag | output | NCH | Per-channel terminal count reached / not armed |

## Verification
A stale captured-edge register shows up as a wrong `grant_ch` at the very next grant. That grant comes two cycles after `bus_grant` falls, so the bench compares it against the expected winner for each mix of pending and newly rising requests, in each window phase. A counter that is off by one shows up as a missing grant or an extra grant near terminal count, or as `tc_flag` changing one unit early or late. The bench checks both on the cycle after `xfer_done`. A state machine fault shows up within a cycle as `cpu_slot` missing or held too long, or as `bus_grant` staying high or dropping early.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10
  } unit_size_e;

  typedef enum logic [1:0] {
    ST_ARB = 2'd0,
    ST_BUS = 2'd1,
    ST_CPU = 2'd2
  } arb_state_e;

endpackage

// File: rtl/dma_prio_pick.sv
module dma_prio_pick #(
  parameter int N = 4,
  localparam int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0] mask,
  output logic         found,
  output logic [W-1:0] idx
);

  // lowest set index wins: scan downward so the last hit is the lowest
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (mask[i]) begin
        found = 1'b1;
        idx   = i[W-1:0];
      end
    end
  end

endmodule

// File: rtl/dma_chan_ctr.sv
module dma_chan_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             tc
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      tc  <= 1'b1;
    end else if (load) begin
      cnt <= load_val;
      tc  <= (load_val == '0);
    end else if (dec && !tc) begin
      cnt <= cnt - 1'b1;
      if (cnt == {{(CNT_W-1){1'b0}}, 1'b1}) tc <= 1'b1;
    end
  end

  // R8: one unit consumed per completed transfer
  a_r8_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !tc && !load) |=> (cnt == $past(cnt) - 1'b1));

  // R8: terminal count holds until a new setup
  a_r8_tc_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (tc && !load) |=> tc);

endmodule

// File: rtl/dma_rise_window.sv
module dma_rise_window #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic         win_open,
  input  logic         clear,
  output logic [N-1:0] fav
);

  logic [N-1:0] req_q;
  logic [N-1:0] rise;

  assign rise = req & ~req_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q <= '0;
      fav   <= '0;
    end else begin
      req_q <= req;
      if (clear)         fav <= '0;
      else if (win_open) fav <= fav | rise;
    end
  end

  // R7: captured set changes only inside the window or when consumed
  a_r7_capture_only_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_open && !clear) |=> $stable(fav));

endmodule

// File: rtl/dma_single_arb.sv
module dma_single_arb
  import dma_arb_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int CNT_W = 16,
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH-1:0]   req,
  input  logic             setup_stb,
  input  logic [CH_W-1:0]  setup_ch,
  input  logic [CNT_W-1:0] setup_cnt,
  input  logic [1:0]       size_sel,
  input  logic             xfer_done,
  output logic             bus_grant,
  output logic [CH_W-1:0]  grant_ch,
  output logic [1:0]       unit_size,
  output logic             cpu_slot,
  output logic [NCH-1:0]   tc_flag
);

  arb_state_e      state;
  logic [CH_W-1:0] gch;
  unit_size_e      size_q;
  unit_size_e      size_in;

  logic [NCH-1:0]  eligible;
  logic [NCH-1:0]  fav;
  logic [NCH-1:0]  fav_live;
  logic            fix_found, fav_found;
  logic [CH_W-1:0] fix_idx, fav_idx;
  logic            unit_end;
  logic            win_open;

  assign eligible = req & ~tc_flag;
  assign fav_live = fav & eligible;
  assign unit_end = (state == ST_BUS) && xfer_done;
  assign win_open = unit_end || (state == ST_CPU);
  assign size_in  = (size_sel == 2'b11) ? SZ_WORD : unit_size_e'(size_sel);

  // per-channel unit counters
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dma_chan_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (setup_stb && (setup_ch == CH_W'(c))),
      .load_val (setup_cnt),
      .dec      (unit_end && (gch == CH_W'(c))),
      .tc       (tc_flag[c])
    );
  end

  dma_rise_window #(.N(NCH)) u_win (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (req),
    .win_open (win_open),
    .clear    (state == ST_ARB),
    .fav      (fav)
  );

  dma_prio_pick #(.N(NCH)) u_fix (
    .mask  (eligible),
    .found (fix_found),
    .idx   (fix_idx)
  );

  dma_prio_pick #(.N(NCH)) u_fav (
    .mask  (fav_live),
    .found (fav_found),
    .idx   (fav_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_ARB;
      gch    <= '0;
      size_q <= SZ_BYTE;
    end else begin
      case (state)
        ST_ARB: if (fix_found) begin
          state  <= ST_BUS;
          gch    <= fav_found ? fav_idx : fix_idx;
          size_q <= size_in;
        end
        ST_BUS: if (xfer_done) state <= ST_CPU;
        ST_CPU: state <= ST_ARB;
        default: state <= ST_ARB;
      endcase
    end
  end

  assign bus_grant = (state == ST_BUS);
  assign cpu_slot  = (state == ST_CPU);
  assign grant_ch  = gch;
  assign unit_size = size_q;

  // R4: the CPU gets the cycle right after every grant
  a_r4_slot_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_grant) |-> cpu_slot);

  // R4: slot lasts one cycle and is followed by an arbitration cycle
  a_r4_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_slot |=> (!bus_grant && !cpu_slot));

  // R3 / R9: grant, channel and size held until the unit completes
  a_r3_hold_until_done: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_grant && !xfer_done) |=> (bus_grant && $stable(grant_ch) && $stable(unit_size)));

  // R8: a terminal channel is never newly granted
  a_r8_no_grant_after_tc: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(bus_grant) && !$past(setup_stb)) |-> !tc_flag[grant_ch]);

  // R6: a live favored request takes the grant
  a_r6_fav_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(bus_grant) && $past(fav_live != '0)) |-> (grant_ch == $past(fav_idx)));

endmodule

// File: tb/dma_single_arb_test.sv
module dma_single_arb_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  req = '0;
  logic        setup_stb = 1'b0;
  logic [1:0]  setup_ch = '0;
  logic [15:0] setup_cnt = '0;
  logic [1:0]  size_sel = '0;
  logic        xfer_done = 1'b0;
  logic        bus_grant;
  logic [1:0]  grant_ch;
  logic [1:0]  unit_size;
  logic        cpu_slot;
  logic [3:0]  tc_flag;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  dma_single_arb uut (
    .clk(clk), .rst_n(rst_n), .req(req), .setup_stb(setup_stb),
    .setup_ch(setup_ch), .setup_cnt(setup_cnt), .size_sel(size_sel),
    .xfer_done(xfer_done), .bus_grant(bus_grant), .grant_ch(grant_ch),
    .unit_size(unit_size), .cpu_slot(cpu_slot), .tc_flag(tc_flag)
  );

  // {pending, rising, phase, expected}; phase 0 = done cycle, 1 = slot cycle,
  // 2 = arbitration cycle, 3 = earlier in grant
  localparam logic [11:0] VEC [12] = '{
    {4'b0001, 4'b0000, 2'd0, 2'd0},
    {4'b0011, 4'b0000, 2'd0, 2'd0},
    {4'b0001, 4'b1000, 2'd0, 2'd3},
    {4'b0011, 4'b0100, 2'd0, 2'd2},
    {4'b0101, 4'b1010, 2'd0, 2'd1},
    {4'b0010, 4'b0001, 2'd0, 2'd0},
    {4'b0110, 4'b1000, 2'd1, 2'd3},
    {4'b0001, 4'b0100, 2'd1, 2'd2},
    {4'b0001, 4'b1000, 2'd2, 2'd0},
    {4'b0001, 4'b1000, 2'd3, 2'd0},
    {4'b1000, 4'b0000, 2'd0, 2'd3},
    {4'b0100, 4'b0011, 2'd1, 2'd0}
  };

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  function automatic int lowest(input logic [3:0] m);
    for (int i = 0; i < 4; i++) if (m[i]) return i;
    return -1;
  endfunction

  task automatic setup(input int ch, input int cnt);
    setup_stb = 1'b1; setup_ch = ch[1:0]; setup_cnt = cnt[15:0];
    @(negedge clk);
    setup_stb = 1'b0;
  endtask

  task automatic finish_unit();
    xfer_done = 1'b1; req = '0;
    @(negedge clk);
    xfer_done = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic run_vec(input logic [11:0] v);
    logic [3:0] pend, rise;
    logic [1:0] ph, exp;
    pend = v[11:8]; rise = v[7:4]; ph = v[3:2]; exp = v[1:0];
    req = pend;
    @(negedge clk);
    check(bus_grant && grant_ch == lowest(pend), "R5 first grant", grant_ch, lowest(pend));
    if (ph == 2'd3) begin req = req | rise; @(negedge clk); end
    xfer_done = 1'b1;
    if (ph == 2'd0) req = req | rise;
    @(negedge clk);
    xfer_done = 1'b0;
    check(cpu_slot && !bus_grant, "R4 slot", {bus_grant, cpu_slot}, 1);
    if (ph == 2'd1) req = req | rise;
    @(negedge clk);
    check(!cpu_slot && !bus_grant, "R4 arb gap", {bus_grant, cpu_slot}, 0);
    if (ph == 2'd2) req = req | rise;
    @(negedge clk);
    if (ph >= 2'd2)
      check(bus_grant && grant_ch == exp, "R7 no favor", grant_ch, exp);
    else
      check(bus_grant && grant_ch == exp, "R6 window winner", grant_ch, exp);
    finish_unit();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!bus_grant && !cpu_slot && grant_ch == 0, "R1 outputs", {bus_grant, cpu_slot}, 0);
    check(tc_flag == 4'b1111, "R1 tc_flag", tc_flag, 15);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 zero count keeps channel unarmed; R8 its request is ignored
    setup(2, 0);
    check(tc_flag[2] == 1'b1, "R2 zero load", tc_flag[2], 1);
    req = 4'b0100;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(!bus_grant, "R8 ignored request", bus_grant, 0);
    end
    req = '0;
    @(negedge clk);

    for (int c = 0; c < 4; c++) setup(c, 1000);
    check(tc_flag == 4'b0000, "R2 armed", tc_flag, 0);

    for (int i = 0; i < 12; i++) run_vec(VEC[i]);

    // R9 size latch and R3 hold without done
    size_sel = 2'b01; req = 4'b0001;
    @(negedge clk);
    check(bus_grant && unit_size == 2'b01, "R9 halfword latched", unit_size, 1);
    size_sel = 2'b10;
    @(negedge clk);
    check(unit_size == 2'b01, "R9 size held", unit_size, 1);
    @(negedge clk);
    check(bus_grant && grant_ch == 0, "R3 held until done", bus_grant, 1);
    finish_unit();
    req = 4'b0001;
    @(negedge clk);
    check(bus_grant && unit_size == 2'b10, "R9 word latched", unit_size, 2);
    xfer_done = 1'b1;
    @(negedge clk);
    xfer_done = 1'b0;
    check(!bus_grant, "R3 drops after done", bus_grant, 0);
    req = '0;
    repeat (2) @(negedge clk);

    // R10 repeated grants until terminal count, R8 flag on 1->0
    setup(1, 2);
    check(tc_flag[1] == 1'b0, "R2 reload clears tc", tc_flag[1], 0);
    req = 4'b0010;
    @(negedge clk);
    check(bus_grant && grant_ch == 1, "R10 first unit", grant_ch, 1);
    xfer_done = 1'b1;
    @(negedge clk);
    xfer_done = 1'b0;
    check(tc_flag[1] == 1'b0, "R8 count 2->1 not terminal", tc_flag[1], 0);
    repeat (2) @(negedge clk);
    check(bus_grant && grant_ch == 1, "R10 second unit", grant_ch, 1);
    xfer_done = 1'b1;
    @(negedge clk);
    xfer_done = 1'b0;
    check(tc_flag[1] == 1'b1, "R8 terminal count", tc_flag[1], 1);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(!bus_grant, "R8 no grant after tc", bus_grant, 0);
    end
    req = '0;

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule